// File: doc/BRIEF.md
# Dual Accumulator with Saturation

This block is the accumulation stage of a signal-processing datapath. It holds two 40-bit signed accumulators, A and B. Each cycle with a valid operation it picks one of them. That accumulator is both the source and the destination of the operation. An incoming 40-bit operand is added to it or subtracted from it. The accumulator side of the adder can be forced to zero, so the same path also loads an operand, or its negation, straight into an accumulator.

The result is checked for overflow in two ways. The first is a spill into the eight guard bits above the 32-bit value; this overflow can be recovered. The second is an overflow out of the top bit, which destroys the sign. Each accumulator has its own saturation enable. One shared mode bit picks the clamp point. Normal mode clamps at a 1.31 value, with the limit at bit 31. Super mode clamps at a 9.31 value, with the limit at bit 39.

Each accumulator has an overflow flag. It describes only the last operation on that accumulator. Each also has a sticky saturation flag, which stays set until a clear input removes it. The block also gives the OR of both overflow flags, the OR of both saturation flags, and a trap request, which is gated by an enable for each accumulator.

Top module: `dual_acc_sat`

## Requirements
- R1: With op_valid high and op_sub low, the selected accumulator takes (op_zero ? 0 : its old value) + op_data, all values as 40-bit two's complement. The other accumulator holds. With op_valid low, all accumulators and flags hold, except the saturation flags, which op_clr_sat still clears.
- R2: With op_valid high and op_sub high, the selected accumulator takes (op_zero ? 0 : its old value) - op_data.
- R3: op_sel = 0 selects accumulator A as both source and destination, and op_sel = 1 selects accumulator B.
- R4: The overflow flag of the selected accumulator is rewritten by every valid operation. It is set when the unsaturated 40-bit result has bits 39..32 not all equal, or when the true result does not fit in 40 bits. Otherwise it is cleared. The flag of the other accumulator holds.
- R5: With saturation enabled for the selected accumulator and sat_super = 0, a true result above 0x007FFFFFFF is stored as 0x007FFFFFFF, and a true result below 0xFF80000000 is stored as 0xFF80000000. The clamp direction follows the sign of the exact 41-bit result.
- R6: With saturation enabled and sat_super = 1, a true result above 0x7FFFFFFFFF is stored as 0x7FFFFFFFFF, and a true result below 0x8000000000 is stored as 0x8000000000.
- R7: With saturation disabled for the selected accumulator, the stored result is the exact result wrapped to 40 bits.
- R8: The saturation flag of the selected accumulator is set when a clamp is applied. With saturation disabled, it is also set when the true result does not fit in 40 bits. It stays set until op_clr_sat, which clears both saturation flags. A set in the same cycle as a clear wins.
- R9: ov_any is ov_a OR ov_b, and sat_any is sat_a OR sat_b.
- R10: trap_req is (ov_a AND trap_en_a) OR (ov_b AND trap_en_b). It follows the enable inputs in the same cycle.
- R11: After reset, both accumulators and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Perform an operation this cycle |
| op_sel | input | 1 | 0 = accumulator A, 1 = accumulator B |
| op_sub | input | 1 | 1 = subtract operand, 0 = add |
| op_zero | input | 1 | Replace the accumulator input of the adder with zero |
| op_data | input | 40 | Signed operand |
| op_clr_sat | input | 1 | Clear both sticky saturation flags |
| sat_en_a | input | 1 | Saturation enable for A |
| sat_en_b | input | 1 | Saturation enable for B |
| sat_super | input | 1 | 0 = clamp at bit 31, 1 = clamp at bit 39 |
| trap_en_a | input | 1 | Trap enable for A overflow |
| trap_en_b | input | 1 | Trap enable for B overflow |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ov_a | output | 1 | A guard-bit overflow from its last operation |
| ov_b | output | 1 | B guard-bit overflow from its last operation |
| sat_a | output | 1 | A sticky saturation flag |
| sat_b | output | 1 | B sticky saturation flag |
| ov_any | output | 1 | OR of ov_a and ov_b |
| sat_any | output | 1 | OR of sat_a and sat_b |
| trap_req | output | 1 | Arithmetic warning trap request |

## Verification
The bench builds the block with its default parameters: a 40-bit accumulator and a normal-mode clamp at bit 31. With these values, both clamp limits lie within a few units of operands the bench can write directly. The bench therefore steps across each limit by small amounts in both modes, with saturation on and off. A reference model runs alongside on integers and is compared every clock. Its stimulus is directed cases plus a long run drawn from operands at the limits. This covers the case where guard bits fill without reaching the clamp point, and the case where one addition of two large values loses the sign.

// File: rtl/dual_acc_sat.sv
module dual_acc_sat #(
  parameter int W       = 40,
  parameter int SAT_MSB = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic         op_sel,
  input  logic         op_sub,
  input  logic         op_zero,
  input  logic [W-1:0] op_data,
  input  logic         op_clr_sat,
  input  logic         sat_en_a,
  input  logic         sat_en_b,
  input  logic         sat_super,
  input  logic         trap_en_a,
  input  logic         trap_en_b,
  output logic [W-1:0] acc_a,
  output logic [W-1:0] acc_b,
  output logic         ov_a,
  output logic         ov_b,
  output logic         sat_a,
  output logic         sat_b,
  output logic         ov_any,
  output logic         sat_any,
  output logic         trap_req
);
  localparam int GB = SAT_MSB + 1;
  localparam logic signed [W:0] N_HI = (W+1)'((64'sd1 <<< SAT_MSB) - 64'sd1);
  localparam logic signed [W:0] N_LO = (W+1)'(-(64'sd1 <<< SAT_MSB));
  localparam logic signed [W:0] S_HI = (W+1)'((64'sd1 <<< (W-1)) - 64'sd1);
  localparam logic signed [W:0] S_LO = (W+1)'(-(64'sd1 <<< (W-1)));

  logic [W-1:0]        src, xin, yin, res;
  logic [W:0]          sum;
  logic [W-1:GB]       guard;
  logic signed [W:0]   hi, lo;
  logic                cat, ov_now, en, over_hi, over_lo, clamp, sat_set;

  assign src   = op_sel ? acc_b : acc_a;
  assign xin   = op_zero ? '0 : src;
  assign yin   = op_sub ? ~op_data : op_data;
  assign sum   = {xin[W-1], xin} + {yin[W-1], yin} + (W+1)'(op_sub);

  assign cat    = sum[W] ^ sum[W-1];
  assign guard  = sum[W-1:GB];
  assign ov_now = cat | ~((&guard) | ~(|guard));

  assign en      = op_sel ? sat_en_b : sat_en_a;
  assign hi      = sat_super ? S_HI : N_HI;
  assign lo      = sat_super ? S_LO : N_LO;
  assign over_hi = $signed(sum) > hi;
  assign over_lo = $signed(sum) < lo;
  assign clamp   = en & (over_hi | over_lo);
  assign res     = !clamp ? sum[W-1:0] : over_hi ? hi[W-1:0] : lo[W-1:0];
  assign sat_set = clamp | (~en & cat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a <= '0;
      acc_b <= '0;
      ov_a  <= 1'b0;
      ov_b  <= 1'b0;
      sat_a <= 1'b0;
      sat_b <= 1'b0;
    end else begin
      sat_a <= (sat_a & ~op_clr_sat) | (op_valid & ~op_sel & sat_set);
      sat_b <= (sat_b & ~op_clr_sat) | (op_valid &  op_sel & sat_set);
      if (op_valid) begin
        if (op_sel) begin
          acc_b <= res;
          ov_b  <= ov_now;
        end else begin
          acc_a <= res;
          ov_a  <= ov_now;
        end
      end
    end
  end

  assign ov_any   = ov_a | ov_b;
  assign sat_any  = sat_a | sat_b;
  assign trap_req = (ov_a & trap_en_a) | (ov_b & trap_en_b);
endmodule

module dual_acc_sat_chk #(
  parameter int W       = 40,
  parameter int SAT_MSB = 31
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         op_sel,
  input logic         op_clr_sat,
  input logic         sat_en_a,
  input logic         sat_super,
  input logic [W-1:0] acc_a,
  input logic [W-1:0] acc_b,
  input logic         ov_a,
  input logic         sat_a,
  input logic         sat_b
);
  // R8
  sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_a && !op_clr_sat) |=> sat_a);

  // R8
  sat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_clr_sat && !op_valid) |=> (!sat_a && !sat_b));

  // R3
  other_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel) |=> (acc_a == $past(acc_a)));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (acc_a == $past(acc_a) && acc_b == $past(acc_b) && ov_a == $past(ov_a)));

  // R5
  normal_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_sel && sat_en_a && !sat_super) |=>
      ((&acc_a[W-1:SAT_MSB]) || !(|acc_a[W-1:SAT_MSB])));
endmodule

bind dual_acc_sat dual_acc_sat_chk #(.W(W), .SAT_MSB(SAT_MSB)) i_chk (.*);

// File: tb/test_dual_acc_sat.sv
module test_dual_acc_sat;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        op_valid = 0, op_sel = 0, op_sub = 0, op_zero = 0, op_clr_sat = 0;
  logic [39:0] op_data = '0;
  logic        sat_en_a = 0, sat_en_b = 0, sat_super = 0, trap_en_a = 0, trap_en_b = 0;
  logic [39:0] acc_a, acc_b;
  logic        ov_a, ov_b, sat_a, sat_b, ov_any, sat_any, trap_req;

  dual_acc_sat i_dual_acc_sat (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  string cur_tag = "R11";
  logic n_en_a = 0, n_en_b = 0, n_super = 0, n_ten_a = 0, n_ten_b = 0;

  longint m_a = 0, m_b = 0;
  bit m_oa = 0, m_ob = 0, m_sa = 0, m_sb = 0;

  function automatic longint sx(logic [39:0] v);
    return longint'({{24{v[39]}}, v});
  endfunction

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("acc_a", sx(acc_a), m_a);
    chk("acc_b", sx(acc_b), m_b);
    chk("ov_a", longint'(ov_a), longint'(m_oa));
    chk("ov_b", longint'(ov_b), longint'(m_ob));
    chk("sat_a", longint'(sat_a), longint'(m_sa));
    chk("sat_b", longint'(sat_b), longint'(m_sb));
    chk("R9 ov_any", longint'(ov_any), longint'(m_oa | m_ob));
    chk("R9 sat_any", longint'(sat_any), longint'(m_sa | m_sb));
    chk("R10 trap_req", longint'(trap_req), longint'((m_oa & trap_en_a) | (m_ob & trap_en_b)));
  endtask

  task automatic step(bit v, bit sel, bit sub, bit zero, logic [39:0] d, bit clr);
    longint x, dv, t, w, hi, lo, r;
    bit en, cat, ov, cl, set;
    @(negedge clk);
    compare();
    op_valid = v; op_sel = sel; op_sub = sub; op_zero = zero; op_data = d; op_clr_sat = clr;
    sat_en_a = n_en_a; sat_en_b = n_en_b; sat_super = n_super;
    trap_en_a = n_ten_a; trap_en_b = n_ten_b;
    if (clr) begin m_sa = 0; m_sb = 0; end
    if (v) begin
      x  = zero ? 0 : (sel ? m_b : m_a);
      dv = sx(d);
      t  = sub ? x - dv : x + dv;
      w  = sx(t[39:0]);
      cat = (t != w);
      ov  = cat || (w < -(64'sd1 <<< 32)) || (w > (64'sd1 <<< 32) - 1);
      hi  = n_super ? (64'sd1 <<< 39) - 1 : (64'sd1 <<< 31) - 1;
      lo  = n_super ? -(64'sd1 <<< 39) : -(64'sd1 <<< 31);
      en  = sel ? n_en_b : n_en_a;
      cl  = en && (t > hi || t < lo);
      r   = !cl ? w : (t > hi ? hi : lo);
      set = cl || (!en && cat);
      if (sel) begin m_b = r; m_ob = ov; if (set) m_sb = 1; end
      else     begin m_a = r; m_oa = ov; if (set) m_sa = 1; end
    end
  endtask

  task automatic op(bit sel, bit sub, bit zero, logic [39:0] d);
    step(1, sel, sub, zero, d, 0);
  endtask

  function automatic logic [39:0] pick();
    case ($urandom_range(0, 9))
      0: return 40'h0;
      1: return 40'h1;
      2: return 40'h007FFFFFFF;
      3: return 40'h0080000000;
      4: return 40'hFF80000000;
      5: return 40'h7FFFFFFFFF;
      6: return 40'h8000000000;
      7: return 40'hFFFFFFFFFF;
      8: return 40'(($urandom_range(0, 255)));
      default: return {8'($urandom), 32'($urandom)};
    endcase
  endfunction

  bit done = 0;

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    #(CLK_PERIOD * 2 + 1);
    rst_n = 1'b1;
    step(0, 0, 0, 0, '0, 0);
    step(0, 0, 0, 0, '0, 0);

    cur_tag = "R3";
    op(0, 0, 1, 40'h0000001234);
    op(1, 0, 1, 40'h00FFFF0000);
    cur_tag = "R1";
    op(0, 0, 0, 40'h5);
    step(0, 1, 0, 0, 40'h99, 0);
    op(1, 0, 0, 40'hFFFFFFFFFF);
    cur_tag = "R2";
    op(1, 1, 0, 40'h10000);
    op(0, 1, 1, 40'h7);

    cur_tag = "R5";
    n_en_a = 1; n_super = 0;
    op(0, 0, 1, 40'h007FFFFFF0);
    op(0, 0, 0, 40'h0F);
    op(0, 0, 0, 40'h01);
    op(0, 0, 0, 40'h20);
    op(0, 0, 1, 40'hFF80000010);
    op(0, 1, 0, 40'h10);
    op(0, 1, 0, 40'h01);
    op(0, 1, 1, 40'h0080000000);
    cur_tag = "R8";
    step(0, 0, 0, 0, '0, 1);
    step(1, 0, 0, 0, 40'h7FFFFFFFFF, 1);
    step(0, 0, 0, 0, '0, 0);
    step(0, 0, 0, 0, '0, 1);

    cur_tag = "R7";
    n_en_a = 0;
    op(0, 0, 1, 40'h007FFFFFF0);
    op(0, 0, 0, 40'h20);
    op(0, 0, 1, 40'h7FFFFFFF00);
    op(0, 0, 0, 40'h200);
    op(0, 1, 1, 40'h8000000000);

    cur_tag = "R6";
    n_en_b = 1; n_super = 1;
    op(1, 0, 1, 40'h7FFFFFFF00);
    op(1, 0, 0, 40'h0FF);
    op(1, 0, 0, 40'h200);
    op(1, 0, 1, 40'h8000000100);
    op(1, 1, 0, 40'h100);
    op(1, 1, 0, 40'h200);
    op(1, 0, 1, 40'h00FFFFFFFF);
    op(1, 0, 0, 40'h1);

    cur_tag = "R4";
    step(0, 0, 0, 0, '0, 1);
    op(0, 0, 1, 40'h00FFFFFFFF);
    op(0, 0, 0, 40'h1);
    op(0, 1, 0, 40'h1);
    op(0, 1, 1, 40'h0100000000);
    op(0, 1, 0, 40'h0);
    cur_tag = "R10";
    n_ten_a = 1;
    op(0, 0, 1, 40'h0100000000);
    n_ten_a = 0; n_ten_b = 1;
    op(1, 0, 1, 40'h0200000000);
    op(0, 0, 1, 40'h0);
    n_ten_b = 0;
    step(0, 0, 0, 0, '0, 0);
    cur_tag = "R9";
    step(0, 0, 0, 0, '0, 0);

    for (int i = 0; i < 4000; i++) begin
      bit sub;
      sub = 1'($urandom);
      cur_tag = sub ? "R2" : "R1";
      if ((i % 50) == 0) begin
        n_en_a = 1'($urandom); n_en_b = 1'($urandom); n_super = 1'($urandom);
        n_ten_a = 1'($urandom); n_ten_b = 1'($urandom);
      end
      step(($urandom_range(0, 7) != 0), 1'($urandom), sub,
           ($urandom_range(0, 3) == 0), pick(), ($urandom_range(0, 15) == 0));
    end
    step(0, 0, 0, 0, '0, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule